// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with LRU Replacement

This block is a small two-way set-associative cache placed between a requester that issues word addresses and a simple line-wide backing memory. Each word address is divided into a block offset (low bits), a set index (next bits) and a tag (remaining high bits). On every access both ways of the indexed set are read, and their tags are compared in parallel. A valid match is a hit and finishes in the cycle of the request.

A miss allocates a line in that set, for reads and writes alike. The victim is the lowest-numbered empty way when one exists. Otherwise it is the way named by a single least-recently-used bit kept for each set. A dirty victim is first written back, then the line is fetched, and the access then completes.

The `WRITE_BACK` parameter selects the write-hit policy. With the value 1, write hits update only the cache and mark the line dirty. With the value 0, write hits also send the word to memory. A flush input walks every line, writes back the dirty ones and signals completion. The memory port carries one request at a time and uses a request/ready handshake, with a write flag and a per-word write strobe.

Top module: `cache2w`

## Requirements
- R1: After reset all lines are invalid and all LRU bits are clear. While no request is present, `ready_o`, `mem_req_o` and `flush_done_o` are low.
- R2: Address fields are offset = `addr_i[OFF_W-1:0]`, set = `addr_i[OFF_W+SET_W-1:OFF_W]` and tag = the remaining upper bits. A request hits when a valid way of the indexed set holds the tag, and at most one way ever matches.
- R3: A read hit (or, in write-back mode, a write hit) raises `ready_o` with `hit_o`=1 in the same cycle as the request. `rdata_o` is then the word of the line selected by the offset.
- R4: On a miss, for a read or a write, `ready_o` stays low until any write-back and the refill have finished. The access then completes with `hit_o`=0, and a read returns the requested word.
- R5: On a miss, if a way of the set is invalid, the lowest-numbered invalid way receives the new line.
- R6: Reads and writes both mark the accessed way as most recently used. On a miss into a full set, the least recently used way is evicted.
- R7: With two sets and block numbers (word address / WORDS) 0, 2, 0, 1, 4, 0, the accesses give miss, miss, hit, miss, miss, hit. A following access to block 2 misses, because block 4 evicted it.
- R8: With `WRITE_BACK`=0, a write hit issues one memory write of the word. `mem_wstrb_o` has the single bit of the offset set, and the access completes when memory accepts the write.
- R9: With `WRITE_BACK`=1, a write hit changes no memory contents and marks the line dirty. A dirty victim is written to memory as a full line (all strobes set) before the refill read.
- R10: A one-cycle `flush_i` while idle and without a request walks every line and writes back each dirty line. It then pulses `flush_done_o` for exactly one cycle. Lines stay valid after the flush.
- R11: `mem_req_o` with `mem_we_o` is a write, and without it is a read. A request stays asserted with a stable address until `mem_ready_i`. Read data is taken from `mem_rdata_i` in the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | Access is a write |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write word |
| ready_o | output | 1 | Access completes this cycle |
| hit_o | output | 1 | Completed access was a hit (valid with `ready_o`) |
| rdata_o | output | DATA_W | Read word (valid with `ready_o`) |
| flush_i | input | 1 | Start a flush of all dirty lines |
| flush_done_o | output | 1 | One-cycle pulse when the flush is finished |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W-OFF_W | Line address |
| mem_wdata_o | output | WORDS*DATA_W | Write line |
| mem_wstrb_o | output | WORDS | Per-word write enable |
| mem_ready_i | input | 1 | Memory accepts or completes the request |
| mem_rdata_i | input | WORDS*DATA_W | Read line, valid with `mem_ready_i` |

## Verification
The bench builds two instances with two sets of two-word lines and an 8-bit word address. This small geometry lets a handful of block numbers fill sets, force evictions and replay the replacement trace exactly. One instance uses `WRITE_BACK`=1 and the other `WRITE_BACK`=0, and both receive the same stimulus. Comparing each instance's own memory model after write hits, evictions and a flush separates immediate write-through from deferred write-back of dirty lines.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_FLUSH
  } cache_st_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SET_W  = 6,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int OFF_W  = 2,
  localparam int SETS   = 1 << SET_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_dirty_i,
  input  logic              clean_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o
);
  logic [SETS-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  assign valid_o = valid_q[set_i];
  assign dirty_o = dirty_q[set_i];
  assign tag_o   = tag_q[set_i];
  assign line_o  = data_q[set_i];
  assign hit_o   = valid_o && (tag_o == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[set_i] <= 1'b1;
      dirty_q[set_i] <= 1'b0;
    end else if (wr_i) begin
      if (wr_dirty_i) dirty_q[set_i] <= 1'b1;
    end else if (clean_i) begin
      dirty_q[set_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[set_i]  <= tag_i;
      data_q[set_i] <= fill_line_i;
    end else if (wr_i) begin
      data_q[set_i][wr_off_i*DATA_W +: DATA_W] <= wr_data_i;
    end
  end
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SET_W = 6,
  localparam int SETS = 1 << SET_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic             way_i,
  output logic             lru_o
);
  // bit per set names the least recently used way
  logic [SETS-1:0] lru_q;

  assign lru_o = lru_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q[set_i] <= ~way_i;
  end

  // R6
  lru_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (lru_q[$past(set_i)] != $past(way_i)));
endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 64,
  parameter int WORDS      = 4,
  parameter bit WRITE_BACK = 1'b1,
  localparam int SET_W   = $clog2(SETS),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORDS * DATA_W,
  localparam int LINES   = 2 * SETS,
  localparam int FCNT_W  = SET_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ready_o,
  output logic               hit_o,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               flush_i,
  output logic               flush_done_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [LADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0]  mem_wdata_o,
  output logic [WORDS-1:0]   mem_wstrb_o,
  input  logic               mem_ready_i,
  input  logic [LINE_W-1:0]  mem_rdata_i
);
  cache_st_e         state_q;
  logic              victim_q, refill_q, done_q;
  logic [FCNT_W-1:0] fl_cnt_q;

  logic [OFF_W-1:0] req_off;
  logic [SET_W-1:0] req_set, fl_set, set_sel;
  logic [TAG_W-1:0] req_tag;
  logic             fl_way;

  assign req_off = addr_i[OFF_W-1:0];
  assign req_set = addr_i[OFF_W +: SET_W];
  assign req_tag = addr_i[ADDR_W-1 -: TAG_W];
  assign fl_way  = fl_cnt_q[0];
  assign fl_set  = fl_cnt_q[FCNT_W-1:1];
  assign set_sel = (state_q == ST_FLUSH) ? fl_set : req_set;

  logic [1:0]        w_hit, w_valid, w_dirty, w_fill, w_wr, w_clean;
  logic [TAG_W-1:0]  w_tag  [2];
  logic [LINE_W-1:0] w_line [2];
  logic              hit, hit_way, victim_c, lru, acc_done;

  assign hit      = |w_hit;
  assign hit_way  = w_hit[1];
  assign victim_c = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru);

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign w_fill[w]  = (state_q == ST_FILL) && mem_ready_i && (victim_q == w[0]);
    assign w_wr[w]    = acc_done && we_i && (hit_way == w[0]);
    assign w_clean[w] = mem_ready_i && mem_req_o && mem_we_o &&
                        (((state_q == ST_EVICT) && (victim_q == w[0])) ||
                         ((state_q == ST_FLUSH) && (fl_way == w[0])));
    cache2w_way #(
      .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .WORDS(WORDS), .OFF_W(OFF_W)
    ) way_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_sel),
      .tag_i      (req_tag),
      .fill_i     (w_fill[w]),
      .fill_line_i(mem_rdata_i),
      .wr_i       (w_wr[w]),
      .wr_off_i   (req_off),
      .wr_data_i  (wdata_i),
      .wr_dirty_i (WRITE_BACK),
      .clean_i    (w_clean[w]),
      .hit_o      (w_hit[w]),
      .valid_o    (w_valid[w]),
      .dirty_o    (w_dirty[w]),
      .tag_o      (w_tag[w]),
      .line_o     (w_line[w])
    );
  end

  cache2w_lru #(.SET_W(SET_W)) lru_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set),
    .touch_i(acc_done),
    .way_i  (hit_way),
    .lru_o  (lru)
  );

  logic [LINE_W-1:0] hit_line;
  assign hit_line = w_line[hit_way];
  assign rdata_o  = hit_line[req_off*DATA_W +: DATA_W];

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {req_tag, req_set};
    mem_wdata_o = {WORDS{wdata_i}};
    mem_wstrb_o = '0;
    acc_done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && hit) begin
          if (!WRITE_BACK && we_i) begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_wstrb_o = WORDS'(1) << req_off;
            acc_done    = mem_ready_i;
          end else begin
            acc_done = 1'b1;
          end
        end
      end
      ST_EVICT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {w_tag[victim_q], req_set};
        mem_wdata_o = w_line[victim_q];
        mem_wstrb_o = '1;
      end
      ST_FILL: mem_req_o = 1'b1;
      ST_FLUSH: begin
        if (w_valid[fl_way] && w_dirty[fl_way]) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = {w_tag[fl_way], fl_set};
          mem_wdata_o = w_line[fl_way];
          mem_wstrb_o = '1;
        end
      end
      default: ;
    endcase
  end

  assign ready_o      = acc_done;
  assign hit_o        = acc_done && !refill_q;
  assign flush_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      victim_q <= 1'b0;
      refill_q <= 1'b0;
      done_q   <= 1'b0;
      fl_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i && !hit) begin
            victim_q <= victim_c;
            state_q  <= (WRITE_BACK && w_valid[victim_c] && w_dirty[victim_c]) ? ST_EVICT : ST_FILL;
          end else if (acc_done) begin
            refill_q <= 1'b0;
          end else if (!req_i && flush_i) begin
            fl_cnt_q <= '0;
            state_q  <= ST_FLUSH;
          end
        end
        ST_EVICT: if (mem_ready_i) state_q <= ST_FILL;
        ST_FILL: begin
          if (mem_ready_i) begin
            refill_q <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        ST_FLUSH: begin
          if (!mem_req_o || mem_ready_i) begin
            if (fl_cnt_q == FCNT_W'(LINES - 1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              fl_cnt_q <= fl_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  way_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(w_hit));
  // R5
  empty_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && !hit && !w_valid[0]) |=> (victim_q == 1'b0));
  // R4
  miss_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && !hit) |-> !ready_o);
  // R9
  wb_no_early_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WRITE_BACK && state_q == ST_IDLE) |-> !(mem_req_o && mem_we_o));
  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && state_q != ST_IDLE) |=> (mem_req_o && $stable(mem_addr_o)));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |=> !flush_done_o);
endmodule

// File: tb/cache2w_tb_top.sv
`timescale 1ns/1ps
module cache2w_tb_mem #(
  parameter int LADDR_W = 7,
  parameter int DATA_W  = 16,
  parameter int WORDS   = 2,
  parameter int LAT     = 2,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               req,
  input  logic               we,
  input  logic [LADDR_W-1:0] addr,
  input  logic [LINE_W-1:0]  wdata,
  input  logic [WORDS-1:0]   wstrb,
  output logic               ready,
  output logic [LINE_W-1:0]  rdata
);
  logic [LINE_W-1:0] mem [1 << LADDR_W];
  int cnt = 0;
  initial
    for (int l = 0; l < (1 << LADDR_W); l++)
      for (int k = 0; k < WORDS; k++)
        mem[l][k*DATA_W +: DATA_W] = DATA_W'(16'hA000 + l * WORDS + k);
  assign ready = req && (cnt == LAT);
  assign rdata = mem[addr];
  always @(posedge clk) begin
    if (req && !ready) cnt <= cnt + 1;
    else cnt <= 0;
    if (req && ready && we)
      for (int k = 0; k < WORDS; k++)
        if (wstrb[k]) mem[addr][k*DATA_W +: DATA_W] <= wdata[k*DATA_W +: DATA_W];
  end
  function automatic logic [DATA_W-1:0] peek(input int waddr);
    logic [LINE_W-1:0] ln;
    ln = mem[waddr / WORDS];
    return ln[(waddr % WORDS)*DATA_W +: DATA_W];
  endfunction
endmodule

module cache2w_tb_top;
  localparam int AW = 8, DW = 16, NW = 2, LAW = 7, LW = 32;
  typedef struct { logic h; logic rd; logic [DW-1:0] d; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] addr = '0;
  logic we = 1'b0, flush = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic req [2];
  logic rdy [2], hit [2], done [2];
  logic [DW-1:0] rdat [2];
  logic mreq [2], mwe [2], mrdy [2];
  logic [LAW-1:0] maddr [2];
  logic [LW-1:0] mwd [2], mrd [2];
  logic [NW-1:0] mst [2];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  exp_t q [2][$];

  cache2w #(.ADDR_W(AW), .DATA_W(DW), .SETS(2), .WORDS(NW), .WRITE_BACK(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(rdy[0]), .hit_o(hit[0]), .rdata_o(rdat[0]), .flush_i(flush), .flush_done_o(done[0]),
    .mem_req_o(mreq[0]), .mem_we_o(mwe[0]), .mem_addr_o(maddr[0]), .mem_wdata_o(mwd[0]),
    .mem_wstrb_o(mst[0]), .mem_ready_i(mrdy[0]), .mem_rdata_i(mrd[0]));
  cache2w #(.ADDR_W(AW), .DATA_W(DW), .SETS(2), .WORDS(NW), .WRITE_BACK(1'b0)) dut_wt_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(rdy[1]), .hit_o(hit[1]), .rdata_o(rdat[1]), .flush_i(flush), .flush_done_o(done[1]),
    .mem_req_o(mreq[1]), .mem_we_o(mwe[1]), .mem_addr_o(maddr[1]), .mem_wdata_o(mwd[1]),
    .mem_wstrb_o(mst[1]), .mem_ready_i(mrdy[1]), .mem_rdata_i(mrd[1]));
  cache2w_tb_mem mem_wb_i (.clk(clk), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]), .wdata(mwd[0]),
    .wstrb(mst[0]), .ready(mrdy[0]), .rdata(mrd[0]));
  cache2w_tb_mem mem_wt_i (.clk(clk), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]), .wdata(mwd[1]),
    .wstrb(mst[1]), .ready(mrdy[1]), .rdata(mrd[1]));

  // reference model: 2 sets x 2 ways, LRU bit names the LRU way
  logic rv [2][2];
  logic [5:0] rt [2][2];
  logic rl [2];
  logic [DW-1:0] shadow [256];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  for (genvar g = 0; g < 2; g++) begin : g_mon
    always @(negedge clk) begin
      if (req[g] && rdy[g]) begin
        exp_t e;
        if (q[g].size() == 0) check("R4 unexpected completion", 1, 0);
        else begin
          e = q[g].pop_front();
          check({e.tag, " hit"}, 32'(hit[g]), 32'(e.h));
          if (e.rd) check({e.tag, " data"}, 32'(rdat[g]), 32'(e.d));
        end
      end
    end
  end

  task automatic acc(input int a, input logic w, input logic [DW-1:0] d, input string tag,
                     input int force_hit = -1);
    int s = (a >> 1) & 1, t = a >> 2, way;
    logic h;
    exp_t e;
    h = (rv[s][0] && rt[s][0] == 6'(t)) || (rv[s][1] && rt[s][1] == 6'(t));
    if (force_hit >= 0 && h !== force_hit[0]) $display("bench model mismatch at %0d", a);
    if (h) way = (rv[s][1] && rt[s][1] == 6'(t)) ? 1 : 0;
    else begin
      way = !rv[s][0] ? 0 : (!rv[s][1] ? 1 : int'(rl[s]));
      rv[s][way] = 1'b1;
      rt[s][way] = 6'(t);
    end
    rl[s] = ~way[0];
    if (w) shadow[a] = d;
    e.h = (force_hit >= 0) ? force_hit[0] : h;
    e.rd = !w; e.d = shadow[a]; e.tag = tag;
    q[0].push_back(e); q[1].push_back(e);
    @(posedge clk); #1;
    addr = AW'(a); we = w; wdata = d; req[0] = 1'b1; req[1] = 1'b1;
    fork
      begin
        int n = 0;
        while (1) begin @(negedge clk); n++; if (rdy[0]) break; end
        if (h) check({tag, " R3 hit latency"}, n, 1);
        else check({tag, " R4 miss waits"}, 32'(n > 1), 1);
        @(posedge clk); #1 req[0] = 1'b0;
      end
      begin
        while (1) begin @(negedge clk); if (rdy[1]) break; end
        @(posedge clk); #1 req[1] = 1'b0;
      end
    join
  endtask

  task automatic do_flush();
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
    fork
      begin
        while (1) begin @(negedge clk); if (done[0]) break; end
        @(negedge clk); check("R10 done one cycle", 32'(done[0]), 0);
      end
      begin
        while (1) begin @(negedge clk); if (done[1]) break; end
      end
    join
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    req[0] = 1'b0; req[1] = 1'b0;
    for (int s = 0; s < 2; s++) begin rl[s] = 1'b0; for (int w = 0; w < 2; w++) begin rv[s][w] = 1'b0; rt[s][w] = '0; end end
    for (int i = 0; i < 256; i++) shadow[i] = DW'(16'hA000 + i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 idle outputs after reset
    check("R1 ready idle", {rdy[0], rdy[1]}, 0);
    check("R1 mem idle", {mreq[0], mreq[1]}, 0);
    check("R1 done idle", {done[0], done[1]}, 0);
    // R7 trace: blocks 0,2,0,1,4,0 -> words 0,4,0,2,8,0
    acc(0, 0, 0, "R7 b0", 0);
    acc(4, 0, 0, "R7 b2", 0);
    acc(0, 0, 0, "R7 b0", 1);
    acc(2, 0, 0, "R7 b1", 0);
    acc(8, 0, 0, "R7 b4", 0);
    acc(0, 0, 0, "R7 b0", 1);
    acc(4, 0, 0, "R7 b2 evicted", 0);
    // R2 offset selects word 1 of a resident line
    acc(5, 0, 0, "R2 offset", 1);
    // R5/R6 set 1: block1 in way0, block3 fills empty way1
    acc(6, 0, 0, "R5 empty way", 0);
    // write hit counts as use
    acc(2, 1, 16'h1234, "R6 write use", 1);
    check("R8 wt memory written", mem_wt_i.peek(2), 16'h1234);
    check("R9 wb memory stale", mem_wb_i.peek(2), 16'hA002);
    acc(10, 0, 0, "R6 evict lru", 0);
    acc(2, 0, 0, "R6 write kept line", 1);
    acc(6, 0, 0, "R6 evicted", 0);
    // evicts dirty block1 in write-back
    acc(14, 0, 0, "R9 dirty victim", 0);
    check("R9 written back", mem_wb_i.peek(2), 16'h1234);
    acc(2, 0, 0, "R9 refetch", 0);
    // write miss allocates
    acc(20, 1, 16'h7777, "R4 write miss", 0);
    acc(20, 0, 0, "R4 write allocate", 1);
    acc(21, 1, 16'h5151, "R3 write hit", 1);
    check("R8 wt strobe word", mem_wt_i.peek(21), 16'h5151);
    check("R9 before flush", mem_wb_i.peek(21), 16'hA015);
    do_flush();
    check("R10 flushed word", mem_wb_i.peek(21), 16'h5151);
    check("R10 flushed word", mem_wb_i.peek(20), 16'h7777);
    check("R11 neighbour word", mem_wb_i.peek(22), 16'hA016);
    acc(20, 0, 0, "R10 still valid", 1);
    repeat (4) @(posedge clk);
    check("R4 queue drained", q[0].size() + q[1].size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule